// File: doc/BRIEF.md
# Audio Transmit Sample FIFO with DMA Request

This block buffers playback samples between a 32-bit register bus, fed by a DMA engine, and a stereo DAC sample port. Software or DMA writes samples to a data register. The block widens each sample to a common 24-bit internal width and stores it in a 64-entry FIFO. In stereo mode a left/right pair takes two consecutive entries, left first. In mono mode each entry drives both channels.

The block raises a DMA request when there is enough free space in the FIFO. The request uses two thresholds, which gives it hysteresis. On the DAC side, every pulse of the sample strobe pops one frame and presents it on the left and right outputs.

A control register selects:
- the sample size;
- how a 16-bit sample is widened;
- mono or stereo framing;
- the thresholds;
- what the outputs carry when the FIFO runs dry.

A status register reports the free space and two sticky error flags. The analog converter, the interpolation filter and clock generation belong to other blocks.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset the free count reads 64, both error flags read 0, `dmaReq` is low and both DAC outputs are 0.
- R2: Writing the control register (offset 0x04) with bit 0 set empties the FIFO. The free count reads 64 afterwards, and bit 0 reads back as 0.
- R3: While the request-enable bit (control bit 4) is 0, `dmaReq` is low one cycle later, whatever the fill level.
- R4: The request uses a trigger level T (control bits 13:8) and a clear count C (control bits 22:21), and acts on the free entry count F one cycle later.
  - It deasserts when F < 2^(C+1). With C=3 this is fewer than 16 free entries.
  - Otherwise it asserts when F >= T.
  - Otherwise it keeps its previous value.
  - When both conditions hold, the deassert wins.
- R5: With control bit 5 = 0, a write to the data register (offset 0x0C) stores bits 15:0 as one sample, and bits 31:16 are ignored. Control bit 24 selects how the sample is widened to 24 bits:
  - 0: the sample is followed by 8 zero bits;
  - 1: the sample is followed by a copy of its own upper 8 bits.
- R6: With control bit 5 = 1, a data write stores bits 31:8 as the 24-bit sample, whatever control bit 24 says.
- R7: In stereo mode (control bit 6 = 0) writes alternate left then right. Each `dacStrobe` with at least two entries stored pops both entries. `dacLeft` and `dacRight` show them from the next cycle and hold between strobes.
- R8: In mono mode (control bit 6 = 1) each `dacStrobe` with at least one entry stored pops one entry and drives it on both outputs.
- R9: A strobe that finds too few entries pops nothing and sets the underrun flag (status bit 8). The outputs then depend on control bit 26:
  - 0: both outputs become 0;
  - 1: both outputs keep their last values.
- R10: A data write while 64 entries are stored is dropped and sets the overrun flag (status bit 9).
- R11: Reading the status register (offset 0x08) returns the free entry count in bits 6:0. Writing 1 to bit 8 or bit 9 clears the matching flag. The control register reads back its stored fields at their bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 6 | Register byte offset |
| busWrEn | input | 1 | Write strobe for one bus write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| dacStrobe | input | 1 | Sample request from the DAC, one cycle per frame |
| dacLeft | output | 24 | Left sample |
| dacRight | output | 24 | Right sample |
| dmaReq | output | 1 | DMA request level |

## Verification
Results appear with the following timing:
- Register reads are combinational, so the free count and flags are valid in the same cycle as the address, once the write edge has passed.
- A frame popped by `dacStrobe` shows on the outputs right after that strobe's edge.
- `dmaReq` trails a change in fill level or control by one more edge.

Every bench operation therefore ends with one extra idle edge before the bench samples status, request and outputs at the falling edge. A reference model updates its request state once per operation. Because the request rule gives the same result when applied again to an unchanged fill level, that single update matches the design.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  localparam int BUS_W    = 32;
  localparam int NARROW_W = 16;
  localparam int TRIG_W   = 6;
  localparam int CLR_W    = 2;

  // register byte offsets
  localparam int OFS_CTRL = 'h04;
  localparam int OFS_STAT = 'h08;
  localparam int OFS_DATA = 'h0C;

  // control bit positions
  localparam int CB_FLUSH   = 0;
  localparam int CB_REQEN   = 4;
  localparam int CB_WIDE    = 5;
  localparam int CB_MONO    = 6;
  localparam int CB_TRIG_LO = 8;
  localparam int CB_CLR_LO  = 21;
  localparam int CB_PAD     = 24;
  localparam int CB_HOLD    = 26;

  // status bit positions
  localparam int SB_UNDER = 8;
  localparam int SB_OVER  = 9;

  typedef struct packed {
    logic              holdLast;
    logic              padRepeat;
    logic [CLR_W-1:0]  clrCnt;
    logic [TRIG_W-1:0] trigLevel;
    logic              monoEn;
    logic              wide;
    logic              reqEn;
  } ctrlFields_t;

  typedef struct packed {
    logic flush;
    logic push;
    logic popMono;
    logic popStereo;
    logic starveZero;
  } fifoStrobes_t;

endpackage

// File: rtl/audio_tx_ctrl.sv
module audio_tx_ctrl
  import audio_tx_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int SAMPLE_W = 24,
  parameter int ADDR_W   = 6,
  parameter int CNT_W    = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [BUS_W-1:0]    busWrData,
  input  logic                dacStrobe,
  input  logic [CNT_W-1:0]    fillCount,
  output ctrlFields_t         ctrlQ,
  output fifoStrobes_t        strb,
  output logic [SAMPLE_W-1:0] pushSample,
  output logic [BUS_W-1:0]    busRdData,
  output logic                dmaReq
);

  localparam int PAD_W = SAMPLE_W - NARROW_W;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic selCtrl, selStat, selData;
  logic wrCtrl, wrStat, wrData;
  logic flushNow, full, enough, starve;
  logic [CNT_W-1:0] availCount, freeCount, clrThr;
  logic underFlag, overFlag;
  logic [NARROW_W-1:0] narrow;

  assign selCtrl = busAddr == ADDR_W'(OFS_CTRL);
  assign selStat = busAddr == ADDR_W'(OFS_STAT);
  assign selData = busAddr == ADDR_W'(OFS_DATA);
  assign wrCtrl  = busWrEn && selCtrl;
  assign wrStat  = busWrEn && selStat;
  assign wrData  = busWrEn && selData;

  assign flushNow   = wrCtrl && busWrData[CB_FLUSH];
  assign availCount = flushNow ? '0 : fillCount;
  assign full       = fillCount == DEPTH_C;
  assign enough     = ctrlQ.monoEn ? (availCount != '0) : (availCount >= CNT_W'(2));
  assign starve     = dacStrobe && !enough;

  // sample widening: 24-bit container or 16-bit with selectable fill
  assign narrow = busWrData[NARROW_W-1:0];
  generate
    if (PAD_W > 0) begin : g_widen
      always_comb begin
        if (ctrlQ.wide)           pushSample = busWrData[BUS_W-1 -: SAMPLE_W];
        else if (ctrlQ.padRepeat) pushSample = {narrow, narrow[NARROW_W-1 -: PAD_W]};
        else                      pushSample = {narrow, {PAD_W{1'b0}}};
      end
    end else begin : g_plain
      assign pushSample = ctrlQ.wide ? busWrData[BUS_W-1 -: SAMPLE_W]
                                     : narrow[NARROW_W-1 -: SAMPLE_W];
    end
  endgenerate

  // strobes toward the datapath
  assign strb.flush      = flushNow;
  assign strb.push       = wrData && !full;
  assign strb.popMono    = dacStrobe && enough && ctrlQ.monoEn;
  assign strb.popStereo  = dacStrobe && enough && !ctrlQ.monoEn;
  assign strb.starveZero = starve && !ctrlQ.holdLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (wrCtrl) begin
      ctrlQ.reqEn     <= busWrData[CB_REQEN];
      ctrlQ.wide      <= busWrData[CB_WIDE];
      ctrlQ.monoEn    <= busWrData[CB_MONO];
      ctrlQ.trigLevel <= busWrData[CB_TRIG_LO +: TRIG_W];
      ctrlQ.clrCnt    <= busWrData[CB_CLR_LO +: CLR_W];
      ctrlQ.padRepeat <= busWrData[CB_PAD];
      ctrlQ.holdLast  <= busWrData[CB_HOLD];
    end
  end

  // sticky flags: a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      underFlag <= 1'b0;
      overFlag  <= 1'b0;
    end else begin
      if (starve)                              underFlag <= 1'b1;
      else if (wrStat && busWrData[SB_UNDER])  underFlag <= 1'b0;
      if (wrData && full)                      overFlag  <= 1'b1;
      else if (wrStat && busWrData[SB_OVER])   overFlag  <= 1'b0;
    end
  end

  // request with hysteresis: clear threshold dominates
  assign freeCount = DEPTH_C - fillCount;
  assign clrThr    = CNT_W'(2) << ctrlQ.clrCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        dmaReq <= 1'b0;
    else if (!ctrlQ.reqEn)                            dmaReq <= 1'b0;
    else if (freeCount < clrThr)                      dmaReq <= 1'b0;
    else if (freeCount >= CNT_W'(ctrlQ.trigLevel))    dmaReq <= 1'b1;
  end

  always_comb begin
    busRdData = '0;
    if (selCtrl) begin
      busRdData[CB_REQEN]               = ctrlQ.reqEn;
      busRdData[CB_WIDE]                = ctrlQ.wide;
      busRdData[CB_MONO]                = ctrlQ.monoEn;
      busRdData[CB_TRIG_LO +: TRIG_W]   = ctrlQ.trigLevel;
      busRdData[CB_CLR_LO +: CLR_W]     = ctrlQ.clrCnt;
      busRdData[CB_PAD]                 = ctrlQ.padRepeat;
      busRdData[CB_HOLD]                = ctrlQ.holdLast;
    end else if (selStat) begin
      busRdData[CNT_W-1:0] = freeCount;
      busRdData[SB_UNDER]  = underFlag;
      busRdData[SB_OVER]   = overFlag;
    end
  end

endmodule

// File: rtl/audio_tx_datapath.sv
module audio_tx_datapath
  import audio_tx_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  fifoStrobes_t        strb,
  input  logic [SAMPLE_W-1:0] pushSample,
  output logic [CNT_W-1:0]    fillCount,
  output logic [SAMPLE_W-1:0] dacLeft,
  output logic [SAMPLE_W-1:0] dacRight
);

  localparam int AW = $clog2(DEPTH);

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [AW-1:0]       wrPtr, rdPtr, rdNext;
  logic [CNT_W-1:0]    popAmt;

  assign rdNext = rdPtr + AW'(1);
  assign popAmt = strb.popStereo ? CNT_W'(2) : (strb.popMono ? CNT_W'(1) : '0);

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= pushSample;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else if (strb.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      wrPtr     <= wrPtr + AW'(strb.push);
      rdPtr     <= rdPtr + popAmt[AW-1:0];
      fillCount <= fillCount + CNT_W'(strb.push) - popAmt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacLeft  <= '0;
      dacRight <= '0;
    end else if (strb.popStereo) begin
      dacLeft  <= mem[rdPtr];
      dacRight <= mem[rdNext];
    end else if (strb.popMono) begin
      dacLeft  <= mem[rdPtr];
      dacRight <= mem[rdPtr];
    end else if (strb.starveZero) begin
      dacLeft  <= '0;
      dacRight <= '0;
    end
  end

endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
  import audio_tx_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int SAMPLE_W = 24,
  parameter int ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  input  logic                dacStrobe,
  output logic [SAMPLE_W-1:0] dacLeft,
  output logic [SAMPLE_W-1:0] dacRight,
  output logic                dmaReq
);

  localparam int CNT_W = $clog2(DEPTH) + 1;

  ctrlFields_t         ctrlQ;
  fifoStrobes_t        strb;
  logic [SAMPLE_W-1:0] pushSample;
  logic [CNT_W-1:0]    fillCount;

  audio_tx_ctrl #(
    .DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .dacStrobe(dacStrobe), .fillCount(fillCount),
    .ctrlQ(ctrlQ), .strb(strb), .pushSample(pushSample),
    .busRdData(busRdData), .dmaReq(dmaReq)
  );

  audio_tx_datapath #(
    .DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .pushSample(pushSample),
    .fillCount(fillCount), .dacLeft(dacLeft), .dacRight(dacRight)
  );

endmodule

// File: rtl/audio_tx_fifo_checks.sv
module audio_tx_fifo_checks
  import audio_tx_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int SAMPLE_W = 24,
  parameter int ADDR_W   = 6,
  parameter int CNT_W    = $clog2(DEPTH) + 1
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic                flushBit,
  input logic                dacStrobe,
  input logic                dmaReq,
  input logic [CNT_W-1:0]    fillCount,
  input logic                reqEn,
  input logic                monoEn,
  input logic                holdLast,
  input logic [SAMPLE_W-1:0] dacLeft,
  input logic [SAMPLE_W-1:0] dacRight
);

  logic ctrlFlush, dataWr;
  assign ctrlFlush = busWrEn && (busAddr == ADDR_W'(OFS_CTRL)) && flushBit;
  assign dataWr    = busWrEn && (busAddr == ADDR_W'(OFS_DATA));

  a_r3_req_gated: assert property (@(posedge clk) disable iff (!rstN)
    !reqEn |=> !dmaReq);

  a_r4_full_no_req: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == CNT_W'(DEPTH)) |=> !dmaReq);

  a_r2_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    ctrlFlush |=> (fillCount == '0));

  a_r10_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  a_r10_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && fillCount == CNT_W'(DEPTH) && !dacStrobe) |=> (fillCount == CNT_W'(DEPTH)));

  a_r8_mono_equal: assert property (@(posedge clk) disable iff (!rstN)
    (dacStrobe && monoEn && fillCount != '0 && !ctrlFlush) |=> (dacLeft == dacRight));

  a_r9_zero_fill: assert property (@(posedge clk) disable iff (!rstN)
    (dacStrobe && !holdLast && fillCount == '0) |=> (dacLeft == '0 && dacRight == '0));

  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !dacStrobe |=> ($stable(dacLeft) && $stable(dacRight)));

endmodule

bind audio_tx_fifo audio_tx_fifo_checks #(
  .DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .flushBit(busWrData[0]), .dacStrobe(dacStrobe), .dmaReq(dmaReq),
  .fillCount(fillCount), .reqEn(ctrlQ.reqEn), .monoEn(ctrlQ.monoEn),
  .holdLast(ctrlQ.holdLast), .dacLeft(dacLeft), .dacRight(dacRight)
);

// File: tb/audio_tx_fifo_test.sv
module audio_tx_fifo_test;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        dacStrobe = 1'b0;
  logic [23:0] dacLeft, dacRight;
  logic        dmaReq;

  always #5 clk = ~clk;

  audio_tx_fifo uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .dacStrobe(dacStrobe),
    .dacLeft(dacLeft), .dacRight(dacRight), .dmaReq(dmaReq)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model
  logic [23:0] q[$];
  bit mMono, mWide, mRep, mHold, mReqEn, mUnder, mOver, mReq;
  int mTrig, mClr;
  logic [23:0] mL = '0, mR = '0;

  task automatic expectEq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCtrl(bit flush, bit reqEn, bit wide, bit mono,
                                         int trig, int clr, bit rep, bit hold);
    logic [31:0] v = '0;
    v[0] = flush; v[4] = reqEn; v[5] = wide; v[6] = mono;
    v[13:8] = trig[5:0]; v[22:21] = clr[1:0]; v[24] = rep; v[26] = hold;
    return v;
  endfunction

  function automatic logic [23:0] packSample(logic [31:0] d, bit wide, bit rep);
    if (wide) return d[31:8];
    if (rep)  return {d[15:0], d[15:8]};
    return {d[15:0], 8'h00};
  endfunction

  task automatic modelReqStep();
    int freeE = DEPTH - q.size();
    int thr = 2 << mClr;
    if (!mReqEn)           mReq = 0;
    else if (freeE < thr)  mReq = 0;
    else if (freeE >= mTrig) mReq = 1;
  endtask

  task automatic readReg(logic [5:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  task automatic settleCheck();
    logic [31:0] st;
    @(negedge clk);
    modelReqStep();
    readReg(6'h08, st);
    expectEq("R11 free count", {25'd0, st[6:0]}, DEPTH - q.size());
    expectEq("R9 underrun flag", st[8], mUnder);
    expectEq("R10 overrun flag", st[9], mOver);
    expectEq("R4 request level", dmaReq, mReq);
    expectEq("R7 left output", dacLeft, mL);
    expectEq("R7 right output", dacRight, mR);
  endtask

  task automatic busWrite(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic setCtrl(bit flush, bit reqEn, bit wide, bit mono,
                         int trig, int clr, bit rep, bit hold);
    busWrite(6'h04, mkCtrl(flush, reqEn, wide, mono, trig, clr, rep, hold));
    mReqEn = reqEn; mWide = wide; mMono = mono; mTrig = trig;
    mClr = clr; mRep = rep; mHold = hold;
    if (flush) q.delete();
    settleCheck();
  endtask

  task automatic pushData(logic [31:0] d);
    busWrite(6'h0C, d);
    if (q.size() >= DEPTH) mOver = 1;
    else q.push_back(packSample(d, mWide, mRep));
    settleCheck();
  endtask

  task automatic clearFlags(bit u, bit o);
    logic [31:0] v = '0;
    v[8] = u; v[9] = o;
    busWrite(6'h08, v);
    if (u) mUnder = 0;
    if (o) mOver = 0;
    settleCheck();
  endtask

  task automatic strobe();
    @(negedge clk);
    dacStrobe = 1'b1;
    @(negedge clk);
    dacStrobe = 1'b0;
    if (q.size() >= (mMono ? 1 : 2)) begin
      mL = q.pop_front();
      mR = mMono ? mL : q.pop_front();
    end else begin
      mUnder = 1;
      if (!mHold) begin mL = '0; mR = '0; end
    end
    settleCheck();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    mMono = 0; mWide = 0; mRep = 0; mHold = 0; mReqEn = 0;
    mUnder = 0; mOver = 0; mReq = 0; mTrig = 0; mClr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readReg(6'h08, v);
    expectEq("R1 free after reset", v[6:0], 64);
    expectEq("R1 flags after reset", v[9:8], 0);
    expectEq("R1 request after reset", dmaReq, 0);
    expectEq("R1 left after reset", dacLeft, 0);
    expectEq("R1 right after reset", dacRight, 0);

    // R5: 16-bit widening, repeat then zero fill
    setCtrl(0, 0, 0, 0, 0, 0, 1, 0);
    pushData(32'hFFFF_1234);
    pushData(32'h0000_ABCD);
    strobe();
    expectEq("R5 repeat fill left", dacLeft, 24'h123412);
    expectEq("R5 repeat fill right", dacRight, 24'hABCDAB);
    setCtrl(0, 0, 0, 0, 0, 0, 0, 0);
    pushData(32'h0000_1234);
    pushData(32'h0000_ABCD);
    strobe();
    expectEq("R5 zero fill left", dacLeft, 24'h123400);
    expectEq("R7 pair order right", dacRight, 24'hABCD00);

    // R6: 24-bit container, padding bit ignored
    setCtrl(0, 0, 1, 0, 0, 0, 1, 0);
    pushData(32'h89AB_CDEF);
    pushData(32'h0123_4567);
    strobe();
    expectEq("R6 wide left", dacLeft, 24'h89ABCD);
    expectEq("R6 wide right", dacRight, 24'h012345);

    // R8: mono duplicates one entry
    setCtrl(0, 0, 0, 1, 0, 0, 0, 0);
    pushData(32'h0000_5A5A);
    strobe();
    expectEq("R8 mono left", dacLeft, 24'h5A5A00);
    expectEq("R8 mono right", dacRight, 24'h5A5A00);

    // R9: underrun zero, partial pair, hold last
    setCtrl(0, 0, 0, 0, 0, 0, 0, 0);
    strobe();
    expectEq("R9 zero on empty", dacLeft, 0);
    readReg(6'h08, v);
    expectEq("R9 underrun set", v[8], 1);
    clearFlags(1, 0);
    readReg(6'h08, v);
    expectEq("R11 underrun cleared", v[8], 0);
    pushData(32'h0000_1111);
    strobe();
    readReg(6'h08, v);
    expectEq("R9 half pair kept", v[6:0], 63);
    pushData(32'h0000_2222);
    strobe();
    expectEq("R7 pair left", dacLeft, 24'h111100);
    setCtrl(0, 0, 0, 0, 0, 0, 0, 1);
    strobe();
    expectEq("R9 hold left", dacLeft, 24'h111100);
    expectEq("R9 hold right", dacRight, 24'h222200);
    clearFlags(1, 1);

    // R2: flush
    pushData(32'h1); pushData(32'h2); pushData(32'h3);
    setCtrl(1, 0, 0, 0, 5, 2, 1, 0);
    readReg(6'h08, v);
    expectEq("R2 flush empties", v[6:0], 64);
    readReg(6'h04, v);
    expectEq("R2 flush bit reads zero", v[0], 0);
    expectEq("R11 control readback", v, mkCtrl(0, 0, 0, 0, 5, 2, 1, 0));

    // R10: overrun
    for (int i = 0; i < DEPTH; i++) pushData(32'(i));
    pushData(32'hDEAD);
    readReg(6'h08, v);
    expectEq("R10 overrun set", v[9], 1);
    expectEq("R10 still full", v[6:0], 0);
    clearFlags(0, 1);

    // R3: request disabled on empty FIFO
    setCtrl(1, 0, 0, 0, 15, 3, 0, 0);
    expectEq("R3 request off when disabled", dmaReq, 0);

    // R4: thresholds and hysteresis
    setCtrl(1, 1, 0, 0, 15, 3, 0, 0);
    expectEq("R4 request on empty", dmaReq, 1);
    for (int i = 0; i < 48; i++) pushData(32'(i));
    expectEq("R4 request at 16 free", dmaReq, 1);
    pushData(32'h77);
    expectEq("R4 request off at 15 free", dmaReq, 0);
    strobe();
    expectEq("R4 request back at 17 free", dmaReq, 1);
    setCtrl(1, 1, 0, 0, 40, 3, 0, 0);
    for (int i = 0; i < 44; i++) pushData(32'(i));
    expectEq("R4 hysteresis holds high", dmaReq, 1);
    for (int i = 0; i < 6; i++) pushData(32'(i));
    expectEq("R4 request cleared below 16", dmaReq, 0);
    repeat (3) strobe();
    expectEq("R4 hysteresis holds low", dmaReq, 0);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int r = $urandom % 100;
      if (r < 8)
        setCtrl(($urandom % 4) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
                $urandom % 64, $urandom % 4, $urandom % 2, $urandom % 2);
      else if (r < 12)
        clearFlags($urandom % 2, $urandom % 2);
      else if (r < 60)
        pushData($urandom);
      else
        strobe();
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule